// File: doc/BRIEF.md
# Synchronous Serial Port, Master or Slave

This block moves one character of 1 to 8 bits over a four-wire synchronous serial link. Every transfer sends and receives at the same time. It can generate the serial clock itself as bus master, or follow a clock and an active-low select from an external master as a slave. A polarity bit and a phase bit select one of four clocking schemes. A 7-bit divisor sets the master bit rate. The transmit driver can be switched off while reception goes on.

Software reaches the block through five byte-wide registers on a 16-bit bus. Writing the transmit register loads the shift register, and in master mode it also starts the character. When the last bit is sampled, the received bits land right-justified in a receive register. A completion flag is raised at the same time and can drive an interrupt line. A character that completes while the flag is still set raises an overrun flag.

Top module: `spi_port`

## Requirements
- R1: The number of bits shifted per character is control[7:5]+1. A master character has exactly twice that many serial clock edges, and the completion flag rises after that many samples.
- R2: Transmission is MSB-first, starting at bit 7 of the written byte. The receive register (address 3) holds the received bits right-justified, with the unused upper bits zero.
- R3: In master mode, one serial clock period is D+1 system clocks. D is the baud register (address 1, bits 6:0), and any value below 3 is treated as 3.
- R4: Control bit 1 sets the idle clock level (1 = idle high). Control bit 2 selects phase delay. Without phase delay, data changes on the leading edge and is sampled on the trailing edge. With phase delay, the first bit is on the line half a period before the first edge, data is sampled on the leading edge, and it changes on the trailing edge.
- R5: With control bit 0 = 0 (slave), the block shifts on `sclk_i` edges only while `ste_n_i` is low. It drives `miso_oe` only while selected and transmit is enabled.
- R6: With control bit 3 = 0, the data output enable stays low, and reception still completes with correct data.
- R7: Registers are 8 bits in the low byte. Reads return zero in bits 15:8, and bits 15:8 of a write are ignored. Map: 0 control, 1 baud, 2 status, 3 receive, 4 transmit.
- R8: Status bit 0 is set when a character completes. It is cleared only by reading address 3. `irq` is high while that flag is set and control bit 4 is 1.
- R9: Status bit 1 (overrun) is set when a character completes while status bit 0 is still set. Writing 1 to status bit 1 clears it.
- R10: Status bit 2 reads 1 while a master character is in progress. A write to address 4 during that time is ignored.
- R11: After reset, all registers read zero, the block is a slave, `irq` is low and both data output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data; only bits 7:0 used |
| bus_rdata | output | 16 | Read data; bits 15:8 zero |
| irq | output | 1 | Completion interrupt |
| sclk_o | output | 1 | Serial clock out (master) |
| sclk_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Enable for mosi_o |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Enable for miso_o |
| miso_i | input | 1 | Master data in |
| ste_n_i | input | 1 | Active-low slave select |

## Verification
A wrong phase or half-period counter shows up within one character. The edge count of `sclk_o` and the spacing of its leading edges will not match the character length and divisor, and the idle level after the character will be wrong. A bit counter or shift register that slips shows at the next completion. The data captured by the remote side and the value in the receive register come out shifted or carry stray upper bits. A flag kept in the wrong state shows on `irq` and in the status byte as soon as the next character completes or the receive register is read.

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port #(
  parameter int BRW = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        sclk_o,
  input  logic        sclk_i,
  output logic        mosi_o,
  output logic        mosi_oe,
  input  logic        mosi_i,
  output logic        miso_o,
  output logic        miso_oe,
  input  logic        miso_i,
  input  logic        ste_n_i
);
  localparam int CW = BRW + 1;
  localparam logic [2:0] A_CTRL = 3'd0, A_BAUD = 3'd1, A_STAT = 3'd2, A_RX = 3'd3, A_TX = 3'd4;

  logic master, cpol, cpha, txen, ien;
  logic [2:0] lenm1, bcnt;
  logic [BRW-1:0] brr;
  logic flag, ovr, busy, act, dout;
  logic [7:0] sr, rxbuf, rbyte;
  logic [4:0] ph;
  logic [CW-1:0] cnt;
  logic [2:0] sck_q;
  logic [1:0] mosi_q, ste_q;

  wire wr    = bus_sel & bus_wr;
  wire rd_rx = bus_sel & ~bus_wr & (bus_addr == A_RX);
  wire tx_wr = wr & (bus_addr == A_TX);
  wire load  = tx_wr & ~(master & busy);

  wire [BRW-1:0] brr_eff = (brr < BRW'(3)) ? BRW'(3) : brr;
  wire [CW-1:0]  div     = {1'b0, brr_eff} + CW'(1);
  wire [CW-1:0]  hlen    = ph[0] ? (div >> 1) : (div - (div >> 1));
  wire [3:0]     nbits   = {1'b0, lenm1} + 4'd1;
  wire [4:0]     last_ph = {nbits, 1'b0} - 5'd1 + {4'd0, cpha};
  wire [7:0]     mask    = 8'hFF >> (3'd7 - lenm1);

  wire ev     = master & busy & (cnt == '0);
  wire m_samp = ev & ph[0];
  wire m_drv  = ev & ~ph[0] & (ph != last_ph);
  wire m_edge = ev & (~cpha | (ph != 5'd0));

  wire s_en   = ~master & ~ste_q[1];
  wire s_edge = s_en & (sck_q[2] != sck_q[1]);
  wire s_lead = sck_q[1] != cpol;
  wire s_samp = s_edge & (s_lead == cpha);
  wire s_drv  = s_edge & (s_lead != cpha);

  wire samp   = master ? m_samp : s_samp;
  wire drive  = master ? m_drv : s_drv;
  wire in_bit = master ? miso_i : mosi_q[1];
  wire [7:0] nsr = {sr[6:0], in_bit};
  wire done   = samp & (bcnt == lenm1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {lenm1, ien, txen, cpha, cpol, master} <= '0;
      brr <= '0; flag <= 1'b0; ovr <= 1'b0; busy <= 1'b0; act <= 1'b0;
      dout <= 1'b0; sr <= '0; rxbuf <= '0; ph <= '0; cnt <= '0; bcnt <= '0;
      sck_q <= '0; mosi_q <= '0; ste_q <= 2'b11;
    end else begin
      sck_q  <= {sck_q[1:0], sclk_i};
      mosi_q <= {mosi_q[0], mosi_i};
      ste_q  <= {ste_q[0], ste_n_i};
      if (wr && bus_addr == A_CTRL) {lenm1, ien, txen, cpha, cpol, master} <= bus_wdata[7:0];
      if (wr && bus_addr == A_BAUD) brr <= bus_wdata[BRW-1:0];

      if (!master) begin
        busy <= 1'b0; act <= 1'b0;
      end else if (busy) begin
        if (m_edge) act <= ~act;
        if (cnt >= hlen - CW'(1)) begin
          cnt <= '0;
          if (ph == last_ph) busy <= 1'b0;
          else ph <= ph + 5'd1;
        end else cnt <= cnt + CW'(1);
      end else if (tx_wr) begin
        busy <= 1'b1; ph <= '0; cnt <= '0;
      end

      if (load) sr <= bus_wdata[7:0];
      else if (samp) sr <= nsr;

      if (load || done || (!master && ste_q[1])) bcnt <= '0;
      else if (samp) bcnt <= bcnt + 3'd1;

      if (drive) dout <= sr[7];
      else if (!master && ste_q[1]) dout <= sr[7];

      if (done) begin
        rxbuf <= nsr & mask;
        flag  <= 1'b1;
        if (flag && !rd_rx) ovr <= 1'b1;
      end else if (rd_rx) flag <= 1'b0;
      if (wr && bus_addr == A_STAT && bus_wdata[1] && !(done && flag && !rd_rx)) ovr <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  rbyte = {lenm1, ien, txen, cpha, cpol, master};
      A_BAUD:  rbyte = 8'(brr);
      A_STAT:  rbyte = {5'd0, busy, ovr, flag};
      A_RX:    rbyte = rxbuf;
      default: rbyte = 8'h00;
    endcase
  end

  assign bus_rdata = {8'h00, rbyte};
  assign irq     = ien & flag;
  assign sclk_o  = master ? (cpol ^ act) : cpol;
  assign mosi_o  = dout;
  assign miso_o  = dout;
  assign mosi_oe = master & txen;
  assign miso_oe = ~master & txen & ~ste_n_i;

  logic unused_bits;
  assign unused_bits = ^bus_wdata[15:8];

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !busy) |-> (sclk_o == cpol));
  assert_rx_justified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ((rxbuf & ~$past(mask)) == 8'h00));
  assert_ovr_after_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(flag));
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(rd_rx));
  assert_sclk_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (master && busy && cnt != '0 && !wr) |=> $stable(sclk_o));
endmodule

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic irq, sclk_o, mosi_o, mosi_oe, miso_o, miso_oe;
  logic sclk_i = 0, mosi_i = 0, ste_n_i = 1, rmiso = 0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_port dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk_o(sclk_o), .sclk_i(sclk_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .miso_i(rmiso), .ste_n_i(ste_n_i));

  // remote device attached to the master side
  bit armed = 0, r_cpol = 0, r_cpha = 0, lead;
  logic [7:0] rsh = 0, cap = 0;
  int edges = 0, nlead = 0;
  realtime t1, t2;
  always @(sclk_o) if (armed) begin
    edges++;
    lead = (sclk_o != r_cpol);
    if (lead) begin
      if (nlead == 0) t1 = $realtime; else if (nlead == 1) t2 = $realtime;
      nlead++;
    end
    if (lead == r_cpha) cap = {cap[6:0], mosi_o};
    else begin rmiso = rsh[7]; rsh = rsh << 1; end
  end

  bit mon = 0, oe_seen = 0;
  always @(negedge clk) if (mon && mosi_oe) oe_seen = 1;

  task automatic chk(input string req, input logic [15:0] a, input logic [15:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd2, s);
      if (!s[2]) break;
    end
  endtask

  task automatic test_reset();
    logic [15:0] d;
    #1;
    chk("R11 irq", {15'd0, irq}, 16'd0);
    chk("R11 oe", {14'd0, mosi_oe, miso_oe}, 16'd0);
    rd(3'd0, d); chk("R11 ctrl", d, 16'h0000);
    rd(3'd2, d); chk("R11 status", d, 16'h0000);
  endtask

  task automatic test_regs();
    logic [15:0] d;
    wr(3'd1, 16'hAB85); rd(3'd1, d); chk("R7 baud upper ignored", d, 16'h0005);
    wr(3'd0, 16'hC3E0); rd(3'd0, d); chk("R7 ctrl upper ignored", d, 16'h00E0);
  endtask

  task automatic test_master(input bit pol, input bit pha, input int n, input logic [6:0] brr,
                             input logic [7:0] t, input logic [7:0] r, input bit tx_on);
    logic [15:0] d;
    int dv;
    armed = 0;
    wr(3'd1, {9'd0, brr});
    wr(3'd0, {8'd0, 3'(n - 1), 1'b1, tx_on, pha, pol, 1'b1});
    r_cpol = pol; r_cpha = pha; edges = 0; nlead = 0; cap = 0; rsh = r;
    if (pha) begin rmiso = r[7]; rsh = r << 1; end
    armed = 1; oe_seen = 0; mon = 1;
    wr(3'd4, {8'd0, t});
    wait_idle();
    mon = 0; armed = 0;
    dv = (brr < 3 ? 3 : int'(brr)) + 1;
    chk("R1 edge count", 16'(edges), 16'(2 * n));
    if (tx_on) chk("R2 remote capture msb first", {8'd0, cap & 8'((9'h1 << n) - 1)}, {8'd0, t >> (8 - n)});
    else chk("R6 data output disabled", {15'd0, oe_seen}, 16'd0);
    if (n > 1) chk("R3 period", 16'(int'((t2 - t1) / 10.0)), 16'(dv));
    chk("R4 idle level", {15'd0, sclk_o}, {15'd0, pol});
    chk("R8 irq raised", {15'd0, irq}, 16'd1);
    rd(3'd3, d); chk("R2 rx right-justified", d, {8'd0, r >> (8 - n)});
    #1 chk("R8 irq cleared by rx read", {15'd0, irq}, 16'd0);
  endtask

  task automatic test_busy_write();
    logic [15:0] d;
    armed = 0;
    wr(3'd1, 16'd6);
    wr(3'd0, {8'd0, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1});
    r_cpol = 0; r_cpha = 0; edges = 0; nlead = 0; cap = 0; rsh = 8'h00; armed = 1;
    wr(3'd4, 16'h005A);
    rd(3'd2, d); chk("R10 busy flag", {15'd0, d[2]}, 16'd1);
    wr(3'd4, 16'h00FF);
    wait_idle(); armed = 0;
    chk("R10 write during busy ignored", {8'd0, cap}, 16'h005A);
    chk("R8 no irq when disabled", {15'd0, irq}, 16'd0);
    wr(3'd4, 16'h0011);
    wait_idle();
    rd(3'd2, d); chk("R9 overrun set", d[1:0], 2'b11);
    wr(3'd2, 16'h0002);
    rd(3'd2, d); chk("R9 overrun cleared", d[1:0], 2'b01);
    rd(3'd3, d);
  endtask

  task automatic test_slave(input bit pol, input bit pha, input int n,
                            input logic [7:0] t, input logic [7:0] m);
    logic [15:0] d;
    logic [7:0] got = 0;
    int h = 8;
    sclk_i = pol; ste_n_i = 1;
    wr(3'd0, {8'd0, 3'(n - 1), 1'b1, 1'b1, pha, pol, 1'b0});
    wr(3'd4, {8'd0, t});
    repeat (4) @(negedge clk);
    ste_n_i = 0;
    if (pha) mosi_i = m[7];
    repeat (h) @(negedge clk);
    chk("R5 miso enabled when selected", {15'd0, miso_oe}, 16'd1);
    for (int i = 0; i < n; i++) begin
      if (!pha) begin
        sclk_i = ~pol; mosi_i = m[7 - i];
        repeat (h) @(negedge clk);
        got = {got[6:0], miso_o};
        sclk_i = pol;
        repeat (h) @(negedge clk);
      end else begin
        got = {got[6:0], miso_o};
        sclk_i = ~pol;
        repeat (h) @(negedge clk);
        sclk_i = pol;
        if (i < n - 1) mosi_i = m[6 - i];
        repeat (h) @(negedge clk);
      end
    end
    ste_n_i = 1;
    repeat (4) @(negedge clk);
    chk("R5 miso released", {15'd0, miso_oe}, 16'd0);
    chk("R5 slave transmit", {8'd0, got}, {8'd0, t >> (8 - n)});
    rd(3'd2, d); chk("R8 slave completion flag", {15'd0, d[0]}, 16'd1);
    rd(3'd3, d); chk("R5 slave receive", d, {8'd0, m >> (8 - n)});
    // select high: edges must not shift
    sclk_i = ~pol; repeat (h) @(negedge clk); sclk_i = pol; repeat (h) @(negedge clk);
    rd(3'd2, d); chk("R5 ignored while deselected", {15'd0, d[0]}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    test_regs();
    test_master(0, 0, 8, 7'd5, 8'hA5, 8'h3C, 1);
    test_master(1, 0, 8, 7'd3, 8'h96, 8'hC3, 1);
    test_master(0, 1, 5, 7'd0, 8'hB8, 8'hE7, 1);
    test_master(1, 1, 1, 7'd4, 8'h80, 8'h80, 1);
    test_master(1, 1, 3, 7'd9, 8'h6D, 8'h4B, 1);
    test_master(0, 0, 6, 7'd4, 8'hF0, 8'h9C, 0);
    test_busy_write();
    test_slave(0, 0, 8, 8'hC6, 8'h59);
    test_slave(1, 1, 8, 8'h3A, 8'hE1);
    test_slave(0, 1, 4, 8'hD0, 8'h70);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule